// File: doc/BRIEF.md
# Potentiometer Register Bank with Row Transfer

This block holds the register state that sits behind the two-wire slave front end of a quad digital potentiometer. Each of the four potentiometers has a volatile wiper register that drives its tap position. A small array of data registers stands behind them, organised in rows with one entry per potentiometer in each row. A status register selects the active row and holds a nonvolatile-enable flag.

The front end hands the block single-cycle write strobes, each carrying a register address, a data byte and the level of the write-protect pin. A status write selects a row and at once reloads every wiper from that row. A potentiometer write goes to the wiper alone, or, when nonvolatile access is enabled and write-protect is high, to the data register of the selected row. A data-register write copies the whole row into the wipers and starts a busy window that models the nonvolatile programming time. The block drops every strobe that arrives inside that window.

Top module: `pot_reg_bank`

## Requirements
- R1: At reset, status_o is 0 (row 0, nonvolatile access off) and busy_o is low. Data register (row r, pot p) resets to 16*r + p, and each wiper p reads p, which is its row 0 value.
- R2: Addresses 0 to 3 select potentiometers 0 to 3 and address 7 selects the status register. An accepted status write stores data bits [2:0]: bit 0 is the nonvolatile enable and bits [2:1] are the row. status_o shows these in bits [2:0] and reads zero in bits [7:3].
- R3: In the cycle after an accepted status write, every wiper holds its data register in the newly selected row, busy_o stays low, and write-protect has no effect.
- R4: With nonvolatile access off, an accepted potentiometer write sets only that wiper to the data in the next cycle. No other wiper changes and busy_o stays low.
- R5: With nonvolatile access on and write-protect high, an accepted potentiometer write stores the data in that potentiometer's data register in the selected row. In the next cycle every wiper holds its data register in that row, so the written wiper shows the new data.
- R6: After a data-register write, busy_o is high for exactly BUSY_CYCLES consecutive cycles, starting in the cycle after the strobe.
- R7: With nonvolatile access on and write-protect low, a potentiometer write updates only its wiper, leaves every data register unchanged and does not raise busy_o.
- R8: Any strobe that arrives while busy_o is high changes no wiper, no data register and no status bit.
- R9: Strobes to addresses 4, 5 and 6 change nothing and do not raise busy_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Single-cycle write strobe |
| wr_addr_i | input | 3 | Register address of the strobe |
| wr_data_i | input | DATA_W | Write data |
| wp_i | input | 1 | Write-protect pin level (high allows nonvolatile writes) |
| wiper_o | output | NUM_POTS*DATA_W | Wiper values, potentiometer p in bits [p*DATA_W +: DATA_W] |
| busy_o | output | 1 | Nonvolatile write cycle in progress |
| status_o | output | DATA_W | Status register contents |

## Verification
The data registers are not visible at the ports, so the hardest cases to show are a write-protect-low write that leaves storage untouched and a strobe dropped inside the busy window. For both, a later status write to the same row brings the stored values out through the wipers. Directed steps set nonvolatile access, write a cell, hit the busy window with status and potentiometer strobes, and then reselect the row. A long run of seeded random strobes follows, with about half of the status writes enabling nonvolatile access. This lands many strobes inside busy windows and gives both write-protect levels.

// File: rtl/pot_bank_pkg.sv
package pot_bank_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd7;

  // reset content of one storage cell: 16*row + pot
  function automatic logic [31:0] dr_seed(int row, int pot);
    return 32'(row * 16 + pot);
  endfunction
endpackage

// File: rtl/pot_dr_array.sv
module pot_dr_array
  import pot_bank_pkg::*;
#(
  parameter int NUM_POTS = 4,
  parameter int NUM_ROWS = 4,
  parameter int DATA_W   = 8,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int POT_W   = $clog2(NUM_POTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ROW_W-1:0]           wrow_i,
  input  logic [POT_W-1:0]           wpot_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [ROW_W-1:0]           rrow_i,
  output logic [NUM_POTS*DATA_W-1:0] row_o
);
  localparam int CELLS = NUM_ROWS * NUM_POTS;

  logic [CELLS*DATA_W-1:0] cells;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cell_q <= DATA_W'(dr_seed(r, p));
        end else if (we_i && wrow_i == ROW_W'(r) && wpot_i == POT_W'(p)) begin
          cell_q <= wdata_i;
        end
      end
      assign cells[(r*NUM_POTS+p)*DATA_W +: DATA_W] = cell_q;
    end
  end

  always_comb begin
    row_o = '0;
    for (int p = 0; p < NUM_POTS; p++) begin
      row_o[p*DATA_W +: DATA_W] = cells[(int'(rrow_i)*NUM_POTS+p)*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pot_wcr_bank.sv
module pot_wcr_bank
  import pot_bank_pkg::*;
#(
  parameter int NUM_POTS = 4,
  parameter int DATA_W   = 8,
  localparam int POT_W   = $clog2(NUM_POTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_row_i,
  input  logic [NUM_POTS*DATA_W-1:0] row_i,
  input  logic                       set_one_i,
  input  logic [POT_W-1:0]           one_idx_i,
  input  logic [DATA_W-1:0]          one_data_i,
  output logic [NUM_POTS*DATA_W-1:0] wiper_o
);
  for (genvar p = 0; p < NUM_POTS; p++) begin : g_wcr
    logic [DATA_W-1:0] wcr_q;
    // single-register set wins over the row copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wcr_q <= DATA_W'(dr_seed(0, p));
      end else if (set_one_i && one_idx_i == POT_W'(p)) begin
        wcr_q <= one_data_i;
      end else if (load_row_i) begin
        wcr_q <= row_i[p*DATA_W +: DATA_W];
      end
    end
    assign wiper_o[p*DATA_W +: DATA_W] = wcr_q;
  end
endmodule

// File: rtl/pot_busy_timer.sv
module pot_busy_timer #(
  parameter int BUSY_CYCLES = 20,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pot_reg_bank.sv
module pot_reg_bank
  import pot_bank_pkg::*;
#(
  parameter int NUM_POTS    = 4,
  parameter int NUM_ROWS    = 4,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_valid_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       wp_i,
  output logic [NUM_POTS*DATA_W-1:0] wiper_o,
  output logic                       busy_o,
  output logic [DATA_W-1:0]          status_o
);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int POT_W = $clog2(NUM_POTS);
  localparam logic [ADDR_W-1:0] POT_LIMIT = ADDR_W'(NUM_POTS);

  logic                       accept, sr_we, pot_we, dr_we;
  logic [ROW_W-1:0]           row_q, rd_row;
  logic                       nv_q;
  logic [POT_W-1:0]           pot_idx;
  logic [NUM_POTS*DATA_W-1:0] row_data;
  logic                       busy;
  logic                       unused_data_hi;

  assign accept  = wr_valid_i && !busy;
  assign sr_we   = accept && (wr_addr_i == STATUS_ADDR);
  assign pot_we  = accept && (wr_addr_i < POT_LIMIT);
  assign dr_we   = pot_we && nv_q && wp_i;
  assign pot_idx = wr_addr_i[POT_W-1:0];
  // a status write reads the row it is about to select
  assign rd_row  = sr_we ? wr_data_i[ROW_W:1] : row_q;
  assign unused_data_hi = ^wr_data_i[DATA_W-1:ROW_W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      nv_q  <= 1'b0;
    end else if (sr_we) begin
      row_q <= wr_data_i[ROW_W:1];
      nv_q  <= wr_data_i[0];
    end
  end

  pot_dr_array #(
    .NUM_POTS(NUM_POTS),
    .NUM_ROWS(NUM_ROWS),
    .DATA_W  (DATA_W)
  ) u_dr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (dr_we),
    .wrow_i (row_q),
    .wpot_i (pot_idx),
    .wdata_i(wr_data_i),
    .rrow_i (rd_row),
    .row_o  (row_data)
  );

  pot_wcr_bank #(
    .NUM_POTS(NUM_POTS),
    .DATA_W  (DATA_W)
  ) u_wcr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_row_i(sr_we || dr_we),
    .row_i     (row_data),
    .set_one_i (pot_we),
    .one_idx_i (pot_idx),
    .one_data_i(wr_data_i),
    .wiper_o   (wiper_o)
  );

  pot_busy_timer #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(dr_we),
    .busy_o (busy)
  );

  assign busy_o   = busy;
  assign status_o = {{(DATA_W-ROW_W-1){1'b0}}, row_q, nv_q};
endmodule

// File: rtl/pot_reg_bank_chk.sv
module pot_reg_bank_chk
  import pot_bank_pkg::*;
#(
  parameter int NUM_POTS    = 4,
  parameter int NUM_ROWS    = 4,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 20
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_valid_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic [DATA_W-1:0]          wr_data_i,
  input logic                       wp_i,
  input logic [NUM_POTS*DATA_W-1:0] wiper_o,
  input logic                       busy_o,
  input logic [DATA_W-1:0]          status_o
);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int POT_W = $clog2(NUM_POTS);
  localparam logic [ADDR_W-1:0] POT_LIMIT = ADDR_W'(NUM_POTS);

  logic acc, acc_pot, acc_sr, acc_unused;
  assign acc        = wr_valid_i && !busy_o;
  assign acc_pot    = acc && (wr_addr_i < POT_LIMIT);
  assign acc_sr     = acc && (wr_addr_i == STATUS_ADDR);
  assign acc_unused = acc && !(wr_addr_i < POT_LIMIT) && (wr_addr_i != STATUS_ADDR);

  int unsigned       run_q;
  logic [POT_W-1:0]  idx_q;
  logic [DATA_W-1:0] sel_wiper;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 0;
      idx_q <= '0;
    end else begin
      run_q <= busy_o ? run_q + 1 : 0;
      idx_q <= wr_addr_i[POT_W-1:0];
    end
  end
  assign sel_wiper = wiper_o[int'(idx_q)*DATA_W +: DATA_W];

  p_status_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_sr |=> status_o == {{(DATA_W-ROW_W-1){1'b0}}, $past(wr_data_i[ROW_W:0])});
  p_status_no_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_sr |=> !busy_o);
  p_pot_takes_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_pot |=> sel_wiper == $past(wr_data_i));
  p_volatile_no_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_pot && !(status_o[0] && wp_i) |=> !busy_o);
  p_nv_write_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_pot && status_o[0] && wp_i |=> busy_o);
  p_busy_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < BUSY_CYCLES);
  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == BUSY_CYCLES);
  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && busy_o |=> $stable(wiper_o) && $stable(status_o));
  p_unused_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_unused |=> $stable(wiper_o) && $stable(status_o) && !busy_o);
endmodule

bind pot_reg_bank pot_reg_bank_chk #(
  .NUM_POTS   (NUM_POTS),
  .NUM_ROWS   (NUM_ROWS),
  .DATA_W     (DATA_W),
  .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .wp_i      (wp_i),
  .wiper_o   (wiper_o),
  .busy_o    (busy_o),
  .status_o  (status_o)
);

// File: tb/tb_pot_reg_bank.sv
`timescale 1ns/1ps
module tb_pot_reg_bank;
  localparam int BUSY = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  data = '0;
  logic        wp = 1'b0;
  logic [31:0] wiper;
  logic        busy;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_dr [4][4];
  logic [7:0] m_wcr [4];
  logic [1:0] m_row;
  logic       m_nv;
  int         m_left;

  always #2.5 clk = ~clk;

  pot_reg_bank #(.BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(valid), .wr_addr_i(addr),
    .wr_data_i(data), .wp_i(wp), .wiper_o(wiper), .busy_o(busy), .status_o(status)
  );

  function automatic logic [31:0] exp_wiper();
    logic [31:0] v;
    for (int p = 0; p < 4; p++) v[p*8 +: 8] = m_wcr[p];
    return v;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "wiper", wiper, exp_wiper());
    check(tag, "busy", 32'(busy), 32'(m_left > 0));
    check(tag, "status", 32'(status), 32'({5'b0, m_row, m_nv}));
  endtask

  // drive after a falling edge, model at the rising edge, sample at the next falling edge
  task automatic step(logic v, logic [2:0] a, logic [7:0] d, logic w);
    string tag;
    logic  nv_write;
    valid = v; addr = a; data = d; wp = w;
    @(posedge clk);
    tag = "R6";
    nv_write = 1'b0;
    if (v) begin
      if (m_left > 0) tag = "R8";
      else if (a == 3'd7) begin
        m_nv = d[0]; m_row = d[2:1];
        for (int p = 0; p < 4; p++) m_wcr[p] = m_dr[m_row][p];
        tag = "R3";
      end else if (a < 3'd4) begin
        if (m_nv && w) begin
          m_dr[m_row][a[1:0]] = d;
          for (int p = 0; p < 4; p++) m_wcr[p] = m_dr[m_row][p];
          nv_write = 1'b1;
          tag = "R5";
        end else begin
          m_wcr[a[1:0]] = d;
          tag = m_nv ? "R7" : "R4";
        end
      end else tag = "R9";
    end
    if (m_left > 0) m_left--;
    if (nv_write) m_left = BUSY;
    @(negedge clk);
    valid = 1'b0;
    compare(tag);
  endtask

  initial begin
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++) m_dr[r][p] = 8'(r * 16 + p);
    for (int p = 0; p < 4; p++) m_wcr[p] = m_dr[0][p];
    m_row = '0; m_nv = 1'b0; m_left = 0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    step(1, 3'd1, 8'h55, 1);           // R4 volatile write, wp ignored
    step(1, 3'd7, 8'hFB, 0);           // R2 upper bits dropped -> 0x03, R3 row 1 reload
    check("R2", "status", 32'(status), 32'h03);
    step(1, 3'd2, 8'h3A, 1);           // R5 stored in row 1, row copied
    check("R5", "wiper2", 32'(wiper[23:16]), 32'h3A);
    step(1, 3'd7, 8'h00, 1);           // R8 ignored while busy
    step(1, 3'd0, 8'hEE, 1);           // R8 ignored while busy
    while (m_left > 0) step(0, 3'd0, 8'h00, 0);  // R6 window length
    step(1, 3'd3, 8'h99, 0);           // R7 wiper only
    step(1, 3'd7, 8'h03, 0);           // reselect row 1 exposes storage
    check("R7", "wiper3_from_dr", 32'(wiper[31:24]), 32'h13);
    check("R8", "wiper0_from_dr", 32'(wiper[7:0]), 32'h10);
    step(1, 3'd5, 8'hAA, 1);           // R9 unused address
    step(1, 3'd4, 8'hAB, 1);
    step(1, 3'd6, 8'hAC, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 3) != 0), a, 8'($urandom), 1'($urandom));
    end
    // final reselect of each row exposes all stored cells
    for (int r = 0; r < 4; r++) begin
      while (m_left > 0) step(0, 3'd0, 8'h00, 0);
      step(1, 3'd7, 8'(r * 2), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R6 actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule